// File: doc/BRIEF.md
# Configurable 32-Pin GPIO Port

This block is a general-purpose I/O port of up to 32 pins on a plain 32-bit register bus. Software can write the output and direction words whole. It can also update them through set and clear aliases, which change only the bits given in the write mask. Each pin also has its own configuration word. This word holds the pin direction, an input-buffer disconnect bit and a pull selection.

For each pin, the block works out the level it senses from three sources, in priority order:

1. The pin's own output driver, when the pin is an output.
2. A tri-state external source, which can drive 0, drive 1, or float.
3. The pull setting.

When nothing drives the pin and no pull is selected, the sensed level keeps its last value. When the pin drives while the external source also drives, a per-pin conflict flag is raised. The flag stays high for as long as both drive.

Bus writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high. `bus_rdata` is combinational from `bus_addr` and the current state. Addresses are word addresses. The map, the configuration word layout and the pull codes are given in the requirements.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, every word at addresses 0x00 to 0x06 reads 0, and every configuration word (address 0x20 + pin) reads 0x2. This means input, buffer disconnected, no pull. `pin_out` and `pin_oe` are 0.
- R2: A write to address 0x00 replaces the output word. A write to 0x01 sets the masked bits, and a write to 0x02 clears them. `pin_out` equals the output word from the edge of the write.
- R3: A write to address 0x04 replaces the direction word. A write to 0x05 sets the masked bits, and a write to 0x06 clears them. `pin_oe` equals the direction word (1 = output).
- R4: Bit 0 of configuration word i always equals direction bit i. Writing a configuration word also writes its bit 0 into direction bit i.
- R5: Reads of 0x01 and 0x02 return the output word. Reads of 0x04, 0x05 and 0x06 return the direction word.
- R6: For an input pin whose buffer is connected (configuration bit 1 = 0) and that has no pull (bits 3:2 = 00 or 10), the sensed bit at address 0x03 follows the external level one edge after it is driven. While the external source floats, the bit keeps its last value.
- R7: Configuration bits 3:2 = 11 make a floating input read 1, and bits 3:2 = 01 make it read 0. This takes effect by the second edge after the configuration write. An external drive overrides the pull.
- R8: A pin whose direction bit is 1 senses its own output bit, even when the external source drives.
- R9: A pin whose buffer is disconnected (configuration bit 1 = 1) reads 0 at address 0x03.
- R10: `short_err[i]` is 1 exactly while direction bit i is 1 and `ext_drive[i]` is 1, in the same cycle.
- R11: Writes to address 0x03 change neither the output word, nor the direction word, nor the sensed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write access |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ext_drive | input | 32 | Per pin: 1 when the external source drives |
| ext_level | input | 32 | Per pin: level driven by the external source |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Output enable per pin |
| short_err | output | 32 | Per pin: driving against an external driver |

## Verification
Register writes are visible on `pin_out`, `pin_oe` and the readback from the edge of the write. A change on the external inputs reaches the sensed word one edge later. A change to a pull or to the direction reaches it at the second edge, because the sensed level is registered. `short_err` responds within the same cycle. Directed reads are taken half a period after the edge that follows the change, so each one sits at or past its due cycle. A behavioural model in the bench applies the same edge counts and is compared two time units after every rising edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int DATA_W = 32;

    // word addresses of the port registers
    localparam int unsigned ADR_OUT    = 0;
    localparam int unsigned ADR_OUTSET = 1;
    localparam int unsigned ADR_OUTCLR = 2;
    localparam int unsigned ADR_IN     = 3;
    localparam int unsigned ADR_DIR    = 4;
    localparam int unsigned ADR_DIRSET = 5;
    localparam int unsigned ADR_DIRCLR = 6;

    typedef enum logic [1:0] {
        PULL_NONE = 2'b00,
        PULL_DOWN = 2'b01,
        PULL_RSVD = 2'b10,
        PULL_UP   = 2'b11
    } pull_e;

    typedef struct packed {
        pull_e pull;
        logic  disc;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RST = '{pull: PULL_NONE, disc: 1'b1};

    typedef enum logic [1:0] {
        OP_LOAD,
        OP_SET,
        OP_CLR
    } wr_op_e;

    typedef struct packed {
        logic   hit;
        wr_op_e op;
    } wr_req_t;

    // pick the update operation from the offset inside a three-word group
    function automatic wr_op_e op_of(input int unsigned rel);
        case (rel)
            1:       return OP_SET;
            2:       return OP_CLR;
            default: return OP_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       req,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  bit_we,
    input  logic [W-1:0]  bit_val,
    output logic [W-1:0]  q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (req.hit) begin
            case (req.op)
                OP_SET:  q <= q | wdata;
                OP_CLR:  q <= q & ~wdata;
                default: q <= wdata;
            endcase
        end else begin
            q <= (q & ~bit_we) | (bit_val & bit_we);
        end
    end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_wd,
    input  logic        dir,
    input  logic        out,
    input  logic        ext_drive,
    input  logic        ext_level,
    output logic [3:0]  cfg_rd,
    output logic        disc,
    output logic        in_bit
);

    pin_cfg_t cfg_q;
    logic     lvl_q;
    logic     lvl_d;

    always_comb begin
        if (dir) begin
            lvl_d = out;
        end else if (ext_drive) begin
            lvl_d = ext_level;
        end else begin
            case (cfg_q.pull)
                PULL_UP:   lvl_d = 1'b1;
                PULL_DOWN: lvl_d = 1'b0;
                default:   lvl_d = lvl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RST;
            lvl_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                cfg_q <= '{pull: pull_e'(cfg_wd[3:2]), disc: cfg_wd[1]};
            end
            lvl_q <= lvl_d;
        end
    end

    assign disc   = cfg_q.disc;
    assign in_bit = lvl_q & ~cfg_q.disc;
    assign cfg_rd = {cfg_q.pull, cfg_q.disc, dir};

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int AW       = 6,
    parameter int CFG_BASE = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  ext_drive,
    input  logic [NPINS-1:0]  ext_level,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  short_err
);

    localparam int PIDX_W = $clog2(NPINS);

    logic             wr;
    logic             cfg_hit;
    logic [AW-1:0]    cfg_idx;
    wr_req_t          out_req;
    wr_req_t          dir_req;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] cfg_we;
    logic [NPINS-1:0] dir_bval;
    logic [NPINS-1:0] in_vec;
    logic [NPINS-1:0] disc_vec;
    logic [3:0]       cfg_rd [NPINS];

    assign wr      = bus_sel & bus_wr;
    assign cfg_idx = bus_addr - AW'(CFG_BASE);
    assign cfg_hit = (bus_addr >= AW'(CFG_BASE)) && (cfg_idx < AW'(NPINS));

    always_comb begin
        out_req.hit = wr && (bus_addr >= AW'(ADR_OUT)) && (bus_addr <= AW'(ADR_OUTCLR));
        out_req.op  = op_of(32'(bus_addr) - ADR_OUT);
        dir_req.hit = wr && (bus_addr >= AW'(ADR_DIR)) && (bus_addr <= AW'(ADR_DIRCLR));
        dir_req.op  = op_of(32'(bus_addr) - ADR_DIR);
    end

    gpio_setclr_reg #(.W(NPINS)) u_out (
        .clk     (clk),
        .rst     (rst),
        .req     (out_req),
        .wdata   (bus_wdata[NPINS-1:0]),
        .bit_we  ('0),
        .bit_val ('0),
        .q       (out_q)
    );

    gpio_setclr_reg #(.W(NPINS)) u_dir (
        .clk     (clk),
        .rst     (rst),
        .req     (dir_req),
        .wdata   (bus_wdata[NPINS-1:0]),
        .bit_we  (cfg_we),
        .bit_val (dir_bval),
        .q       (dir_q)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign cfg_we[g]   = wr && cfg_hit && (cfg_idx == AW'(g));
        assign dir_bval[g] = bus_wdata[0];

        gpio_pin_ctrl u_pin (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we[g]),
            .cfg_wd    (bus_wdata[3:0]),
            .dir       (dir_q[g]),
            .out       (out_q[g]),
            .ext_drive (ext_drive[g]),
            .ext_level (ext_level[g]),
            .cfg_rd    (cfg_rd[g]),
            .disc      (disc_vec[g]),
            .in_bit    (in_vec[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (cfg_hit) begin
            bus_rdata = DATA_W'(cfg_rd[cfg_idx[PIDX_W-1:0]]);
        end else begin
            case (32'(bus_addr))
                ADR_OUT, ADR_OUTSET, ADR_OUTCLR: bus_rdata = DATA_W'(out_q);
                ADR_IN:                          bus_rdata = DATA_W'(in_vec);
                ADR_DIR, ADR_DIRSET, ADR_DIRCLR: bus_rdata = DATA_W'(dir_q);
                default:                         bus_rdata = '0;
            endcase
        end
    end

    assign pin_out   = out_q;
    assign pin_oe    = dir_q;
    assign short_err = dir_q & ext_drive;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  ext_drive,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  short_err,
    input logic [NPINS-1:0]  disc_vec
);

    logic wr;
    assign wr = bus_sel && bus_wr;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && pin_oe == '0));

    // R3
    dirset_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == AW'(ADR_DIRSET)) |=>
        ((pin_oe & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    // R2
    outclr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == AW'(ADR_OUTCLR)) |=>
        ((pin_out & $past(bus_wdata[NPINS-1:0])) == '0));

    // R9
    disc_in_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == AW'(ADR_IN)) |-> ((bus_rdata[NPINS-1:0] & disc_vec) == '0));

    // R10
    short_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_drive == '0) |-> (short_err == '0));

    // R11
    in_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == AW'(ADR_IN)) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_drive (ext_drive),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .short_err (short_err),
    .disc_vec  (disc_vec)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ext_drive = '0;
    logic [31:0] ext_level = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [31:0] short_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    gpio_port u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_drive(ext_drive), .ext_level(ext_level),
        .pin_out(pin_out), .pin_oe(pin_oe), .short_err(short_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [31:0] m_out, m_dir, m_disc, m_lvl, nl;
    logic [1:0]  m_pull [32];

    always @(posedge clk) begin
        if (rst) begin
            m_out = 0; m_dir = 0; m_disc = '1; m_lvl = 0;
            for (int i = 0; i < 32; i++) m_pull[i] = 2'b00;
        end else begin
            nl = m_lvl;
            for (int i = 0; i < 32; i++) begin
                if (m_dir[i])                nl[i] = m_out[i];
                else if (ext_drive[i])       nl[i] = ext_level[i];
                else if (m_pull[i] == 2'b11) nl[i] = 1'b1;
                else if (m_pull[i] == 2'b01) nl[i] = 1'b0;
            end
            m_lvl = nl;
            if (bus_sel && bus_wr) begin
                if (bus_addr == 0) m_out = bus_wdata;
                if (bus_addr == 1) m_out = m_out | bus_wdata;
                if (bus_addr == 2) m_out = m_out & ~bus_wdata;
                if (bus_addr == 4) m_dir = bus_wdata;
                if (bus_addr == 5) m_dir = m_dir | bus_wdata;
                if (bus_addr == 6) m_dir = m_dir & ~bus_wdata;
                if (bus_addr >= 32) begin
                    m_dir[bus_addr-32]  = bus_wdata[0];
                    m_disc[bus_addr-32] = bus_wdata[1];
                    m_pull[bus_addr-32] = bus_wdata[3:2];
                end
            end
        end
    end

    function automatic logic [31:0] mread(input int a);
        if (a >= 32) return {28'd0, m_pull[a-32], m_disc[a-32], m_dir[a-32]};
        case (a)
            0, 1, 2: return m_out;
            3:       return m_lvl & ~m_disc;
            4, 5, 6: return m_dir;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R2 R3 R6 R10)
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            chk("R2", "model pin_out", pin_out, m_out);
            chk("R3", "model pin_oe", pin_oe, m_dir);
            chk("R10", "model short_err", short_err, m_dir & ext_drive);
            chk("R6", "model rdata", bus_rdata, mread(int'(bus_addr)));
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 6'(a);
        #1 d = bus_rdata;
    endtask

    task automatic setx(input logic drv, input logic lvl);
        @(negedge clk);
        ext_drive[0] = drv; ext_level[0] = lvl;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(a, v); chk("R1", "reset word", v, 0);
        end
        rd(32, v); chk("R1", "cfg0 reset", v, 32'h2);
        rd(63, v); chk("R1", "cfg31 reset", v, 32'h2);
        chk("R1", "pin_oe reset", pin_oe, 0);

        // R3 R4 R5 direction paths
        wr(5, 32'h8000_0001);
        rd(4, v);  chk("R3", "dirset", v, 32'h8000_0001);
        chk("R3", "pin_oe", pin_oe, 32'h8000_0001);
        rd(32, v); chk("R4", "cfg0 dir bit", v & 1, 1);
        rd(63, v); chk("R4", "cfg31 dir bit", v & 1, 1);
        rd(5, v);  chk("R5", "dirset read", v, 32'h8000_0001);
        rd(6, v);  chk("R5", "dirclr read", v, 32'h8000_0001);
        wr(6, 32'h8000_0001);
        rd(4, v);  chk("R3", "dirclr", v, 0);
        rd(32, v); chk("R4", "cfg0 dir cleared", v & 1, 0);
        wr(4, 32'h8000_0001);
        rd(4, v);  chk("R3", "dir load", v, 32'h8000_0001);
        wr(4, 0);
        wr(37, 32'h1);
        rd(4, v);  chk("R4", "cfg write sets dir", v, 32'h20);
        rd(37, v); chk("R4", "cfg5 readback", v, 32'h1);
        wr(37, 32'h2);

        // R6 connected input, no pull
        wr(32, 0);
        setx(1, 0); rd(3, v); chk("R6", "ext 0", v & 1, 0);
        setx(1, 1); rd(3, v); chk("R6", "ext 1", v & 1, 1);
        setx(0, 0); rd(3, v); chk("R6", "float holds", v & 1, 1);

        // R7 pulls
        wr(32, 32'hC); rd(3, v); chk("R7", "pull up", v & 1, 1);
        wr(32, 32'h4); rd(3, v); chk("R7", "pull down", v & 1, 0);
        setx(1, 1); rd(3, v); chk("R7", "drive beats pull", v & 1, 1);
        setx(0, 0);

        // R9 disconnected
        wr(32, 32'h2);
        setx(1, 1); rd(3, v); chk("R9", "disconnected", v & 1, 0);
        setx(0, 0);

        // R2 R8 output and loopback
        wr(32, 32'h1);
        wr(1, 32'h1);
        chk("R2", "outset pin", pin_out & 1, 1);
        rd(3, v); chk("R8", "loopback 1", v & 1, 1);
        rd(1, v); chk("R5", "outset read", v, 1);
        rd(2, v); chk("R5", "outclr read", v, 1);
        wr(2, 32'h1);
        chk("R2", "outclr pin", pin_out & 1, 0);
        rd(3, v); chk("R8", "loopback 0", v & 1, 0);
        wr(0, 32'hF0); rd(0, v); chk("R2", "out load", v, 32'hF0);
        wr(1, 32'h3);  rd(0, v); chk("R2", "out set", v, 32'hF3);
        wr(2, 32'hF0); rd(0, v); chk("R2", "out clr", v, 32'h3);

        // R10 conflict, R8 output wins
        setx(1, 0);
        #1 chk("R10", "short raised", short_err, 32'h1);
        rd(3, v); chk("R8", "output beats ext", v & 1, 1);
        setx(0, 0);
        #1 chk("R10", "short dropped", short_err, 0);

        // R11 writes to the sensed word are ignored
        wr(3, 32'hFFFF_FFFF);
        rd(3, v); chk("R11", "in unchanged", v, 32'h1);
        rd(0, v); chk("R11", "out unchanged", v, 32'h3);
        chk("R11", "oe unchanged", pin_oe, 32'h1);

        repeat (2) @(posedge clk);
        #3;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule